// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the hardware half of a polled receive path. A stream of packet beats comes in from the line side. The engine places each packet into the buffer that belongs to the descriptor at the current head position. When the last beat arrives, it marks that descriptor complete and moves head forward. Software never receives an interrupt. Instead it reads a per-descriptor status word until the done flag shows. It then reads the buffer words, clears the flag, and hands the descriptor back by moving the tail index.

Four control values sit behind a single word-wide register port: a ring base address, the number of active descriptors, head and tail. The same port reads a saturating count of dropped packets, the status word of each descriptor, the address of each descriptor's buffer (ring base plus index times buffer size), and every word of buffer storage. The buffers are an internal array, sixteen descriptors of 64 bytes each by default.

Top module: `rxr_engine`

## Requirements
- R1: After reset, ring base reads 0, ring size reads 16, head, tail and the drop count read 0, and every descriptor status word reads 0.
- R2: The data words of an accepted packet are stored in order in the buffer of the descriptor at head. Word w of descriptor d reads at address 0x200 + 16*d + w.
- R3: In the clock edge that takes a packet's last beat, the status word of its descriptor (address 0x100 + d) becomes done = bit 16 set, with the byte length in bits 15:0. The length is 4 per beat, except that the last beat counts pkt_nbytes bytes, and pkt_nbytes = 0 stands for 4.
- R4: Each completed packet moves head (address 0x002) one place forward, and head wraps to 0 when it reaches the ring size.
- R5: A packet that starts while head+1 (wrapped) equals tail (address 0x003) is discarded whole. Buffers, status and head stay unchanged, and the drop count (address 0x004) rises by one, holding at 255.
- R6: A packet longer than 64 bytes keeps only its first 16 words. Its status shows a length of 64 and an overflow flag in bit 17.
- R7: Writing a status word can only clear bits. A 0 in bit 16 or bit 17 clears done or overflow, a 1 leaves the bit as it was, and the length field does not change.
- R8: When the engine starts filling a descriptor, that descriptor's status goes to 0 and stays there until the last beat. A descriptor that software released without clearing therefore never shows a stale done flag.
- R9: The ring size register (address 0x001) takes only values from 2 to 16. Head and tail writes take only values below the ring size. Any other write leaves the register unchanged.
- R10: Reading address 0x180 + d returns ring base (address 0x000) plus 64*d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pkt_valid | input | 1 | Packet beat present |
| pkt_data | input | 32 | Packet beat data |
| pkt_last | input | 1 | Beat is the last of its packet |
| pkt_nbytes | input | 2 | Valid bytes in the last beat, 0 meaning 4 |

## Verification
Every result of this block becomes visible in the cycle after the clock edge that causes it. Buffer words, status, head and the drop count are all readable right after the edge that takes the deciding beat, and register writes take effect after their own edge. The bench drives beats and writes on the falling edge and reads the combinational read port just after a later falling edge, so each read sees one full rising edge of effect. For the mid-packet status check, the bench deliberately pauses the packet between its first and last beat and reads in that gap.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned ADDR_W = 10;

   // control register word addresses
   localparam logic [ADDR_W-1:0] A_BASE  = 10'h000;
   localparam logic [ADDR_W-1:0] A_SIZE  = 10'h001;
   localparam logic [ADDR_W-1:0] A_HEAD  = 10'h002;
   localparam logic [ADDR_W-1:0] A_TAIL  = 10'h003;
   localparam logic [ADDR_W-1:0] A_DROPS = 10'h004;

   // address regions selected by reg_addr[9:7]
   localparam logic [2:0] RGN_STAT  = 3'b010;
   localparam logic [2:0] RGN_DADDR = 3'b011;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_FILL,
      FS_SKIP
   } fill_state_e;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
   import rxr_pkg::*;
#(
   parameter int unsigned NUM_DESC = 16,
   parameter int unsigned DROP_W   = 8,
   parameter bit          DROP_SAT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [REG_W-1:0]          wdata,
   input  logic                      adv,
   input  logic                      drop_evt,
   output logic [REG_W-1:0]          ring_base,
   output logic [$clog2(NUM_DESC):0] ring_size,
   output logic [$clog2(NUM_DESC)-1:0] head,
   output logic [$clog2(NUM_DESC)-1:0] tail,
   output logic [DROP_W-1:0]         drops,
   output logic                      full
);
   localparam int unsigned IDX_W = $clog2(NUM_DESC);

   logic [IDX_W:0] head_inc;
   logic [IDX_W:0] head_nxt;
   logic           idx_ok;
   logic           size_ok;

   assign head_inc = {1'b0, head} + 1'b1;
   assign head_nxt = (head_inc == ring_size) ? '0 : head_inc;
   assign full     = (head_nxt == {1'b0, tail});
   assign idx_ok   = (wdata < REG_W'(ring_size));
   assign size_ok  = (wdata >= REG_W'(2)) && (wdata <= REG_W'(NUM_DESC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_base <= '0;
         ring_size <= (IDX_W+1)'(NUM_DESC);
         head      <= '0;
         tail      <= '0;
      end else begin
         if (wr && addr == A_BASE) ring_base <= wdata;
         if (wr && addr == A_SIZE && size_ok) ring_size <= wdata[IDX_W:0];
         if (wr && addr == A_TAIL && idx_ok) tail <= wdata[IDX_W-1:0];
         // a completion always wins over a software head write
         if (adv) head <= head_nxt[IDX_W-1:0];
         else if (wr && addr == A_HEAD && idx_ok) head <= wdata[IDX_W-1:0];
      end
   end

   generate
      if (DROP_SAT) begin : g_drop_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) drops <= '0;
            else if (drop_evt && drops != '1) drops <= drops + 1'b1;
         end
      end else begin : g_drop_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) drops <= '0;
            else if (drop_evt) drops <= drops + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/rxr_fill.sv
module rxr_fill
   import rxr_pkg::*;
#(
   parameter int unsigned NUM_DESC  = 16,
   parameter int unsigned BUF_BYTES = 64,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LEN_W     = 16
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      pkt_valid,
   input  logic                                      pkt_last,
   input  logic [$clog2(DATA_W/8)-1:0]               pkt_nbytes,
   input  logic                                      full,
   input  logic [$clog2(NUM_DESC)-1:0]               head,
   output logic                                      buf_we,
   output logic [$clog2(NUM_DESC)-1:0]               buf_idx,
   output logic [$clog2(BUF_BYTES/(DATA_W/8))-1:0]   buf_word,
   output logic                                      clr_valid,
   output logic                                      cmp_valid,
   output logic [LEN_W-1:0]                          cmp_len,
   output logic                                      cmp_ovf,
   output logic                                      drop_evt
);
   localparam int unsigned BPW    = DATA_W / 8;
   localparam int unsigned WORDS  = BUF_BYTES / BPW;
   localparam int unsigned IDX_W  = $clog2(NUM_DESC);
   localparam int unsigned WORD_W = $clog2(WORDS);
   localparam int unsigned ACC_W  = $clog2(BUF_BYTES + 2*BPW + 2);

   fill_state_e        state;
   logic [IDX_W-1:0]   cur_idx;
   logic [WORD_W:0]    beat_q;
   logic [WORD_W:0]    beat;
   logic [ACC_W-1:0]   acc_q;
   logic [ACC_W-1:0]   acc_base;
   logic [ACC_W-1:0]   beat_bytes;
   logic [ACC_W-1:0]   total;
   logic [ACC_W-1:0]   total_cap;
   logic               start;
   logic               accept;
   logic               take;

   assign start      = (state == FS_IDLE) && pkt_valid;
   assign accept     = start && !full;
   assign drop_evt   = start && full;
   assign take       = accept || (state == FS_FILL && pkt_valid);
   assign beat       = (state == FS_IDLE) ? '0 : beat_q;
   assign acc_base   = (state == FS_IDLE) ? '0 : acc_q;
   assign beat_bytes = (pkt_last && pkt_nbytes != '0) ? ACC_W'(pkt_nbytes) : ACC_W'(BPW);
   assign total      = acc_base + beat_bytes;
   assign total_cap  = (total > ACC_W'(BUF_BYTES)) ? ACC_W'(BUF_BYTES + 1) : total;

   assign buf_idx    = (state == FS_IDLE) ? head : cur_idx;
   assign buf_word   = beat[WORD_W-1:0];
   assign buf_we     = take && (beat < (WORD_W+1)'(WORDS));
   assign clr_valid  = accept;
   assign cmp_valid  = take && pkt_last;
   assign cmp_ovf    = (total > ACC_W'(BUF_BYTES));
   assign cmp_len    = cmp_ovf ? LEN_W'(BUF_BYTES) : LEN_W'(total);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= FS_IDLE;
         cur_idx <= '0;
         beat_q  <= '0;
         acc_q   <= '0;
      end else begin
         unique case (state)
            FS_IDLE: begin
               if (accept && !pkt_last) begin
                  state   <= FS_FILL;
                  cur_idx <= head;
                  beat_q  <= (WORD_W+1)'(1);
                  acc_q   <= total_cap;
               end else if (drop_evt && !pkt_last) begin
                  state <= FS_SKIP;
               end
            end
            FS_FILL: begin
               if (pkt_valid) begin
                  if (pkt_last) begin
                     state <= FS_IDLE;
                  end else begin
                     if (beat_q < (WORD_W+1)'(WORDS)) beat_q <= beat_q + 1'b1;
                     acc_q <= total_cap;
                  end
               end
            end
            FS_SKIP: begin
               if (pkt_valid && pkt_last) state <= FS_IDLE;
            end
            default: state <= FS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxr_store.sv
module rxr_store #(
   parameter int unsigned NUM_DESC  = 16,
   parameter int unsigned BUF_BYTES = 64,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LEN_W     = 16
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     buf_we,
   input  logic [$clog2(NUM_DESC)-1:0]              buf_idx,
   input  logic [$clog2(BUF_BYTES/(DATA_W/8))-1:0]  buf_word,
   input  logic [DATA_W-1:0]                        buf_wdata,
   input  logic                                     clr_valid,
   input  logic                                     cmp_valid,
   input  logic [LEN_W-1:0]                         cmp_len,
   input  logic                                     cmp_ovf,
   input  logic                                     sw_we,
   input  logic [$clog2(NUM_DESC)-1:0]              sw_idx,
   input  logic                                     sw_keep_done,
   input  logic                                     sw_keep_ovf,
   input  logic [$clog2(NUM_DESC)-1:0]              rd_stat_idx,
   output logic [LEN_W+1:0]                         rd_stat,
   input  logic [$clog2(NUM_DESC)-1:0]              rd_buf_idx,
   input  logic [$clog2(BUF_BYTES/(DATA_W/8))-1:0]  rd_buf_word,
   output logic [DATA_W-1:0]                        rd_buf_data
);
   localparam int unsigned WORDS = BUF_BYTES / (DATA_W/8);
   localparam int unsigned IDX_W = $clog2(NUM_DESC);
   localparam int unsigned ST_W  = LEN_W + 2;

   logic [DATA_W-1:0] mem  [NUM_DESC*WORDS];
   logic [ST_W-1:0]   stat [NUM_DESC];

   always_ff @(posedge clk) begin
      if (buf_we) mem[{buf_idx, buf_word}] <= buf_wdata;
   end

   assign rd_buf_data = mem[{rd_buf_idx, rd_buf_word}];
   assign rd_stat     = stat[rd_stat_idx];

   generate
      for (genvar d = 0; d < NUM_DESC; d++) begin : g_desc
         logic             done_q;
         logic             ovf_q;
         logic [LEN_W-1:0] len_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               done_q <= 1'b0;
               ovf_q  <= 1'b0;
               len_q  <= '0;
            end else if (cmp_valid && buf_idx == IDX_W'(d)) begin
               done_q <= 1'b1;
               ovf_q  <= cmp_ovf;
               len_q  <= cmp_len;
            end else if (clr_valid && buf_idx == IDX_W'(d)) begin
               done_q <= 1'b0;
               ovf_q  <= 1'b0;
               len_q  <= '0;
            end else if (sw_we && sw_idx == IDX_W'(d)) begin
               done_q <= done_q & sw_keep_done;
               ovf_q  <= ovf_q & sw_keep_ovf;
            end
         end

         assign stat[d] = {ovf_q, done_q, len_q};
      end
   endgenerate
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
   import rxr_pkg::*;
#(
   parameter int unsigned NUM_DESC  = 16,
   parameter int unsigned BUF_BYTES = 64,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned DROP_W    = 8,
   parameter bit          DROP_SAT  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [REG_W-1:0]              reg_wdata,
   output logic [REG_W-1:0]              reg_rdata,
   input  logic                          pkt_valid,
   input  logic [DATA_W-1:0]             pkt_data,
   input  logic                          pkt_last,
   input  logic [$clog2(DATA_W/8)-1:0]   pkt_nbytes
);
   localparam int unsigned BPW    = DATA_W / 8;
   localparam int unsigned WORDS  = BUF_BYTES / BPW;
   localparam int unsigned IDX_W  = $clog2(NUM_DESC);
   localparam int unsigned WORD_W = $clog2(WORDS);
   localparam int unsigned BUF_SH = $clog2(BUF_BYTES);

   generate
      if (NUM_DESC < 2 || NUM_DESC > 64 || (NUM_DESC & (NUM_DESC - 1)) != 0) begin : g_bad_desc
         $error("NUM_DESC must be a power of two from 2 to 64");
      end
      if (DATA_W != 16 && DATA_W != 32) begin : g_bad_data
         $error("DATA_W must be 16 or 32");
      end
      if (WORDS < 2 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
         $error("BUF_BYTES must be a power of two holding at least two words");
      end
      if (NUM_DESC * WORDS > 512) begin : g_bad_map
         $error("buffer storage exceeds the 512-word read window");
      end
      if (LEN_W + 2 > REG_W || (1 << LEN_W) <= BUF_BYTES) begin : g_bad_len
         $error("LEN_W must hold BUF_BYTES and fit a status word");
      end
      if (DROP_W < 1 || DROP_W > REG_W) begin : g_bad_drop
         $error("DROP_W must be 1 to 32");
      end
   endgenerate

   logic [REG_W-1:0]  ring_base_q;
   logic [IDX_W:0]    size_q;
   logic [IDX_W-1:0]  head_q;
   logic [IDX_W-1:0]  tail_q;
   logic [DROP_W-1:0] drops_q;
   logic              full;
   logic              buf_we;
   logic [IDX_W-1:0]  buf_idx;
   logic [WORD_W-1:0] buf_word;
   logic              clr_valid;
   logic              cmp_valid;
   logic [LEN_W-1:0]  cmp_len;
   logic              cmp_ovf;
   logic              drop_evt;
   logic [LEN_W+1:0]  rd_stat;
   logic [DATA_W-1:0] rd_buf_data;

   logic [2:0]        rgn;
   logic [8:0]        lin;
   logic              lin_ok;
   logic              sel_ok;
   logic [IDX_W-1:0]  sel_idx;
   logic              sw_we;

   assign rgn     = reg_addr[9:7];
   assign lin     = reg_addr[8:0];
   assign lin_ok  = (lin >> (WORD_W + IDX_W)) == '0;
   assign sel_ok  = (reg_addr[6:0] < 7'(NUM_DESC));
   assign sel_idx = reg_addr[IDX_W-1:0];
   assign sw_we   = reg_wr && rgn == RGN_STAT && sel_ok;

   rxr_regs #(
      .NUM_DESC (NUM_DESC),
      .DROP_W   (DROP_W),
      .DROP_SAT (DROP_SAT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .adv       (cmp_valid),
      .drop_evt  (drop_evt),
      .ring_base (ring_base_q),
      .ring_size (size_q),
      .head      (head_q),
      .tail      (tail_q),
      .drops     (drops_q),
      .full      (full)
   );

   rxr_fill #(
      .NUM_DESC  (NUM_DESC),
      .BUF_BYTES (BUF_BYTES),
      .DATA_W    (DATA_W),
      .LEN_W     (LEN_W)
   ) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .pkt_valid  (pkt_valid),
      .pkt_last   (pkt_last),
      .pkt_nbytes (pkt_nbytes),
      .full       (full),
      .head       (head_q),
      .buf_we     (buf_we),
      .buf_idx    (buf_idx),
      .buf_word   (buf_word),
      .clr_valid  (clr_valid),
      .cmp_valid  (cmp_valid),
      .cmp_len    (cmp_len),
      .cmp_ovf    (cmp_ovf),
      .drop_evt   (drop_evt)
   );

   rxr_store #(
      .NUM_DESC  (NUM_DESC),
      .BUF_BYTES (BUF_BYTES),
      .DATA_W    (DATA_W),
      .LEN_W     (LEN_W)
   ) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .buf_we       (buf_we),
      .buf_idx      (buf_idx),
      .buf_word     (buf_word),
      .buf_wdata    (pkt_data),
      .clr_valid    (clr_valid),
      .cmp_valid    (cmp_valid),
      .cmp_len      (cmp_len),
      .cmp_ovf      (cmp_ovf),
      .sw_we        (sw_we),
      .sw_idx       (sel_idx),
      .sw_keep_done (reg_wdata[LEN_W]),
      .sw_keep_ovf  (reg_wdata[LEN_W+1]),
      .rd_stat_idx  (sel_idx),
      .rd_stat      (rd_stat),
      .rd_buf_idx   (lin[WORD_W +: IDX_W]),
      .rd_buf_word  (lin[WORD_W-1:0]),
      .rd_buf_data  (rd_buf_data)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr[9]) begin
         if (lin_ok) reg_rdata = REG_W'(rd_buf_data);
      end else if (rgn == RGN_STAT) begin
         if (sel_ok) reg_rdata = REG_W'(rd_stat);
      end else if (rgn == RGN_DADDR) begin
         if (sel_ok) reg_rdata = ring_base_q + (REG_W'(sel_idx) << BUF_SH);
      end else begin
         unique case (reg_addr)
            A_BASE:  reg_rdata = ring_base_q;
            A_SIZE:  reg_rdata = REG_W'(size_q);
            A_HEAD:  reg_rdata = REG_W'(head_q);
            A_TAIL:  reg_rdata = REG_W'(tail_q);
            A_DROPS: reg_rdata = REG_W'(drops_q);
            default: reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk #(
   parameter int unsigned NUM_DESC  = 16,
   parameter int unsigned BUF_BYTES = 64,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned DROP_W    = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [$clog2(NUM_DESC)-1:0]   head_q,
   input logic [$clog2(NUM_DESC):0]     size_q,
   input logic [DROP_W-1:0]             drops_q,
   input logic                          cmp_valid,
   input logic [LEN_W-1:0]              cmp_len,
   input logic                          cmp_ovf,
   input logic                          drop_evt
);
   localparam int unsigned IDX_W = $clog2(NUM_DESC);

   logic [IDX_W:0] head_inc;
   assign head_inc = {1'b0, head_q} + 1'b1;

   // R4: a completion moves head by one with wrap at the ring size
   p_head_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |=> head_q == (($past(head_inc) == $past(size_q)) ? '0 : $past(head_inc[IDX_W-1:0])));

   // R5: a dropped packet never completes in the same cycle
   p_drop_no_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      drop_evt |-> !cmp_valid);

   // R5: each drop below the ceiling adds exactly one
   p_drop_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_evt && drops_q != '1) |=> drops_q == $past(drops_q) + 1'b1);

   // R5: a saturated count stays saturated
   p_drop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      drops_q == '1 |=> drops_q == '1);

   // R6: reported length never exceeds the buffer
   p_len_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |-> cmp_len <= LEN_W'(BUF_BYTES));

   // R6: overflow always reports the full buffer length
   p_ovf_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && cmp_ovf) |-> cmp_len == LEN_W'(BUF_BYTES));

   // R9: ring size stays within its legal range
   p_size_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      size_q >= (IDX_W+1)'(2) && size_q <= (IDX_W+1)'(NUM_DESC));
endmodule

bind rxr_engine rxr_engine_chk #(
   .NUM_DESC  (NUM_DESC),
   .BUF_BYTES (BUF_BYTES),
   .LEN_W     (LEN_W),
   .DROP_W    (DROP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .head_q    (head_q),
   .size_q    (size_q),
   .drops_q   (drops_q),
   .cmp_valid (cmp_valid),
   .cmp_len   (cmp_len),
   .cmp_ovf   (cmp_ovf),
   .drop_evt  (drop_evt)
);

// File: tb/rxr_engine_bench.sv
module rxr_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;
   localparam int ND         = 16;
   localparam int NW         = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pkt_valid = 1'b0;
   logic [31:0] pkt_data = '0;
   logic        pkt_last = 1'b0;
   logic [1:0]  pkt_nbytes = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxr_engine u_rxr_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .pkt_valid  (pkt_valid),
      .pkt_data   (pkt_data),
      .pkt_last   (pkt_last),
      .pkt_nbytes (pkt_nbytes)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] m_buf [ND*NW];
   bit          m_bv  [ND*NW];
   logic [31:0] m_stat [ND];
   logic [31:0] m_base;
   int m_head, m_tail, m_size, m_drops;
   logic [31:0] pw [32];

   function automatic int ring_next(int h, int sz);
      return (h + 1 == sz) ? 0 : h + 1;
   endfunction

   function automatic int pkt_bytes(int beats, int lastb);
      return 4 * (beats - 1) + ((lastb == 0) ? 4 : lastb);
   endfunction

   function automatic logic [31:0] exp_status(int bytes);
      logic [31:0] s;
      s = 32'h0001_0000;
      if (bytes > 64) s = s | 32'h0002_0000 | 32'd64;
      else s = s | 32'(bytes);
      return s;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_write(int a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a[9:0]; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a[9:0];
      #1 d = reg_rdata;
   endtask

   task automatic drive_beat(logic [31:0] d, bit last, int lastb);
      @(negedge clk);
      pkt_valid = 1'b1; pkt_data = d; pkt_last = last;
      pkt_nbytes = last ? lastb[1:0] : 2'd0;
      @(negedge clk);
      pkt_valid = 1'b0; pkt_last = 1'b0;
   endtask

   task automatic model_apply(int beats, int lastb);
      if (ring_next(m_head, m_size) == m_tail) begin
         if (m_drops < 255) m_drops++;
      end else begin
         for (int w = 0; w < beats && w < NW; w++) begin
            m_buf[m_head*NW + w] = pw[w];
            m_bv[m_head*NW + w]  = 1'b1;
         end
         m_stat[m_head] = exp_status(pkt_bytes(beats, lastb));
         m_head = ring_next(m_head, m_size);
      end
   endtask

   task automatic send_pkt(int beats, int lastb);
      for (int b = 0; b < beats; b++) pw[b] = $urandom;
      for (int b = 0; b < beats; b++) drive_beat(pw[b], b == beats - 1, lastb);
      model_apply(beats, lastb);
   endtask

   task automatic check_ctrl(string tag);
      logic [31:0] v;
      reg_read(2, v); chk({tag, " R4 head"}, v, 32'(m_head));
      reg_read(3, v); chk({tag, " R9 tail"}, v, 32'(m_tail));
      reg_read(4, v); chk({tag, " R5 drops"}, v, 32'(m_drops));
      reg_read(1, v); chk({tag, " R9 size"}, v, 32'(m_size));
   endtask

   task automatic check_desc(int d, string tag);
      logic [31:0] v;
      reg_read(32'h100 + d, v); chk({tag, " R3 status"}, v, m_stat[d]);
      for (int w = 0; w < NW; w++) begin
         if (m_bv[d*NW + w]) begin
            reg_read(32'h200 + d*NW + w, v);
            chk({tag, " R2 buffer word"}, v, m_buf[d*NW + w]);
         end
      end
   endtask

   task automatic check_all(string tag);
      check_ctrl(tag);
      for (int d = 0; d < ND; d++) check_desc(d, tag);
   endtask

   task automatic consume(bit clear_done);
      if (m_tail != m_head) begin
         if (clear_done) begin
            reg_write(32'h100 + m_tail, 32'h0);
            m_stat[m_tail] = m_stat[m_tail] & ~32'h0003_0000;
         end
         m_tail = ring_next(m_tail, m_size);
         reg_write(3, 32'(m_tail));
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < ND*NW; i++) begin m_buf[i] = '0; m_bv[i] = 1'b0; end
      for (int d = 0; d < ND; d++) m_stat[d] = '0;
      m_base = '0; m_head = 0; m_tail = 0; m_size = 16; m_drops = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_read(0, v); chk("R1 base", v, 32'h0);
      check_all("R1 reset");

      // R10 descriptor buffer address
      m_base = 32'h4000_0000;
      reg_write(0, m_base);
      reg_read(0, v); chk("R10 base readback", v, m_base);
      reg_read(32'h183, v); chk("R10 address of desc 3", v, 32'h4000_00C0);
      reg_read(32'h18F, v); chk("R10 address of desc 15", v, 32'h4000_03C0);

      // R2 R3 single-beat packet with one byte, then a three-beat packet
      send_pkt(1, 1);
      reg_read(32'h100, v); chk("R3 one byte length", v, 32'h0001_0001);
      send_pkt(3, 0);
      reg_read(32'h101, v); chk("R3 twelve byte length", v, 32'h0001_000C);
      // R6 truncation: 17 beats, then exactly 16 beats
      send_pkt(17, 2);
      reg_read(32'h102, v); chk("R6 truncated status", v, 32'h0003_0040);
      send_pkt(16, 0);
      reg_read(32'h103, v); chk("R6 exact 64 bytes no overflow", v, 32'h0001_0040);
      check_all("R2 R4 directed");

      // R7 status writes only clear
      reg_write(32'h102, 32'h0001_0000);
      m_stat[2] = 32'h0001_0040;
      reg_read(32'h102, v); chk("R7 clear overflow keep done", v, m_stat[2]);
      reg_write(32'h101, 32'h0000_FFFF);
      m_stat[1] = 32'h0000_000C;
      reg_read(32'h101, v); chk("R7 clear done length kept", v, m_stat[1]);
      reg_write(32'h101, 32'h0003_0000);
      reg_read(32'h101, v); chk("R7 writing ones sets nothing", v, m_stat[1]);

      // R5 fill to full, then drops
      while (ring_next(m_head, m_size) != m_tail) send_pkt(2, 3);
      reg_read(2, v); chk("R5 head at full", v, 32'd15);
      send_pkt(4, 0);
      send_pkt(1, 0);
      check_all("R5 full drops");

      // R8 release two descriptors without clearing, then reuse desc 0 mid-fill
      m_tail = 2; reg_write(3, 32'd2);
      send_pkt(1, 0);
      reg_read(2, v); chk("R4 head wraps to 0", v, 32'd0);
      pw[0] = $urandom; pw[1] = $urandom;
      drive_beat(pw[0], 1'b0, 0);
      reg_read(32'h100, v); chk("R8 reused desc status cleared mid-fill", v, 32'h0);
      drive_beat(pw[1], 1'b1, 2);
      model_apply(2, 2);
      reg_read(32'h100, v); chk("R8 reused desc completes", v, 32'h0001_0006);
      check_all("R8 reuse");

      // R9 illegal writes ignored
      reg_write(1, 32'd1);
      reg_write(1, 32'd17);
      reg_write(2, 32'd16);
      reg_write(3, 32'd40);
      check_ctrl("R9 illegal writes");

      // R9 R4 smaller ring of 4 descriptors
      reg_write(1, 32'd4); m_size = 4;
      reg_write(2, 32'd0); m_head = 0;
      reg_write(3, 32'd0); m_tail = 0;
      for (int i = 0; i < 4; i++) send_pkt(1 + i, 0);
      check_ctrl("R9 size 4 full");
      consume(1'b1);
      send_pkt(2, 1);
      reg_read(2, v); chk("R4 wrap at size 4", v, 32'd0);
      check_all("R9 small ring");

      // random phase on a full-size ring
      reg_write(1, 32'd16); m_size = 16;
      reg_write(2, 32'd0); m_head = 0;
      reg_write(3, 32'd0); m_tail = 0;
      for (int it = 0; it < 300; it++) begin
         int r;
         r = $urandom % 4;
         if (r < 2) send_pkt(1 + ($urandom % 20), $urandom % 4);
         else consume(r == 2);
         if (it % 30 == 29) check_all("R2 R3 random");
      end

      // R5 saturation of the drop count
      while (ring_next(m_head, m_size) != m_tail) send_pkt(1, 0);
      for (int i = 0; i < 260; i++) send_pkt(1, 0);
      reg_read(4, v); chk("R5 drop count saturates", v, 32'd255);
      check_all("R5 saturated");

      summary();
      $finish;
   end
endmodule